// File: doc/BRIEF.md
# Clock-Enable Power State Controller

This block follows the low-power state of a double data rate memory device as seen from its controller. It samples the clock enable once per clock and, on the first cycle that clock enable is seen low after being high, decides which power-down state to enter. The choice depends on whether any bank is open and on the command presented in that same cycle. It then holds that state until clock enable returns high. The states it tracks are: waiting for initialisation, idle, active (some bank open), active power-down, idle power-down, self-refresh and deep power-down.

Deep power-down discards the device contents. Leaving it does not return to idle. The machine goes back to the initialisation wait state, and only an asserted initialisation-done input moves it on. While the machine is in any state where commands are not accepted, it raises a command-block output. Any command other than a no-operation seen in such a state sets a protocol-error flag. The flag stays set until reset in the default configuration.

The command input is the chip select (active low) plus a 3-bit opcode formed from the first three command/address lines. Opcode bit 2 carries the first line, bit 1 the second and bit 0 the third.

Top module: `pwr_state_ctl`

## Requirements
- R1: After reset, pstate is 0 (waiting for initialisation), cmd_block is 1 and proto_err is 0. In state 0 the machine stays put until init_done is sampled high, and then enters idle (1) on the next cycle.
- R2: In idle (1) or active (2), when there is no power-down entry, the next state is active (2) if bank_open is high and idle (1) if it is low. cmd_block is 0 in both states.
- R3: An entry cycle is one where cke is sampled low and the previous sample was high, taken in idle or active. If bank_open is high in an entry cycle, the next state is active power-down (3), whatever the command.
- R4: An entry cycle with bank_open low and a no-operation leads to idle power-down (4). A no-operation is sel_n high, or opcode 3'b111.
- R5: An entry cycle with bank_open low, sel_n low and opcode 3'b001 (refresh) leads to self-refresh (5).
- R6: An entry cycle with bank_open low, sel_n low and opcode 3'b110 (burst terminate) leads to deep power-down (6).
- R7: Entry happens only in the first low sample of cke. If cke is low without having been high in the previous sample, the state stays in idle/active tracking as in R2, whatever the command.
- R8: In states 3, 4 and 5 the state holds while cke is low. On a high sample of cke, state 3 returns to active (2), and states 4 and 5 return to idle (1). cmd_block is 1 in states 0, 3, 4, 5 and 6.
- R9: Deep power-down (6) ignores init_done and holds while cke is low. A high sample of cke moves it to state 0, which then needs init_done as in R1.
- R10: proto_err rises on the cycle after a non-no-operation command is sampled in state 0, 3, 4, 5 or 6. It also rises after an entry cycle with bank_open low and any other command besides refresh and burst terminate; that entry goes to idle power-down (4). proto_err stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Sampled clock enable of the device |
| sel_n | input | 1 | Chip select, active low; high means no-operation |
| opcode | input | 3 | First three command/address lines, bit 2 = first line |
| bank_open | input | 1 | High while at least one bank is open |
| init_done | input | 1 | Reset/initialisation sequence completed |
| pstate | output | 3 | Current state code (0 init, 1 idle, 2 active, 3 active power-down, 4 idle power-down, 5 self-refresh, 6 deep power-down) |
| cmd_block | output | 1 | High while commands must not be issued |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The bench covers several corner cases:
- A refresh command entering with a bank open must go to active power-down. A design that ranked the opcode first would land in self-refresh.
- Clock enable held low from reset through initialisation must not trigger an entry. A level-sensitive design would drop into a power-down state.
- init_done is raised while in deep power-down, and exit is then checked to go to the initialisation wait. A design that exited straight to idle, or that honoured init_done early, would show a wrong state code.
- A read-like opcode is sent at entry and a stray command is sent inside idle power-down, and the bench checks that the error flag rises and persists. A missing or non-sticky flag would show up as a mismatch against the reference model on every later clock.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

   localparam int STATE_W = 3;

   typedef enum logic [STATE_W-1:0] {
      ST_INIT   = 3'd0,
      ST_IDLE   = 3'd1,
      ST_ACTIVE = 3'd2,
      ST_APD    = 3'd3,
      ST_IPD    = 3'd4,
      ST_SR     = 3'd5,
      ST_DPD    = 3'd6
   } pstate_t;

endpackage

// File: rtl/pwr_cke_edge.sv
// Registers the sampled clock enable and flags its first low sample.
module pwr_cke_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic cke,
   output logic fall
);
   logic cke_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cke_q <= 1'b0;
      else        cke_q <= cke;
   end

   assign fall = cke_q & ~cke;
endmodule

// File: rtl/pwr_entry_dec.sv
// Picks the power-down state entered in an entry cycle.
module pwr_entry_dec
   import pwr_pkg::*;
#(
   parameter int               OP_W   = 3,
   parameter logic [OP_W-1:0]  OP_REF = 3'b001,
   parameter logic [OP_W-1:0]  OP_BST = 3'b110
) (
   input  logic            bank_open,
   input  logic            is_nop,
   input  logic [OP_W-1:0] opcode,
   output pstate_t         target,
   output logic            illegal
);
   always_comb begin
      target  = ST_IPD;
      illegal = 1'b0;
      if (bank_open) begin
         target = ST_APD;
      end else if (is_nop) begin
         target = ST_IPD;
      end else if (opcode == OP_REF) begin
         target = ST_SR;
      end else if (opcode == OP_BST) begin
         target = ST_DPD;
      end else begin
         target  = ST_IPD;
         illegal = 1'b1;
      end
   end
endmodule

// File: rtl/pwr_err_flag.sv
// Protocol-error flag, sticky or single-cycle by parameter.
module pwr_err_flag #(
   parameter bit STICKY = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   output logic flag
);
   logic flag_q;

   generate
      if (STICKY) begin : g_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= flag_q | set;
         end
      end else begin : g_pulse
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= set;
         end
      end
   endgenerate

   assign flag = flag_q;
endmodule

// File: rtl/pwr_state_ctl.sv
// Clock-enable driven power state controller.
module pwr_state_ctl
   import pwr_pkg::*;
#(
   parameter int               OP_W       = 3,
   parameter logic [OP_W-1:0]  OP_NOP     = 3'b111,
   parameter logic [OP_W-1:0]  OP_REF     = 3'b001,
   parameter logic [OP_W-1:0]  OP_BST     = 3'b110,
   parameter bit               ERR_STICKY = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cke,
   input  logic               sel_n,
   input  logic [OP_W-1:0]    opcode,
   input  logic               bank_open,
   input  logic               init_done,
   output logic [STATE_W-1:0] pstate,
   output logic               cmd_block,
   output logic               proto_err
);
   // elaboration checks
   if (OP_W != 3) begin : g_bad_width
      $error("pwr_state_ctl: OP_W must be 3");
   end
   if (OP_NOP == OP_REF || OP_NOP == OP_BST || OP_REF == OP_BST) begin : g_bad_ops
      $error("pwr_state_ctl: opcodes must be distinct");
   end

   pstate_t st_q, st_d, entry_tgt;
   logic    fall, is_nop, entry_bad, awake, blocked, err_set;

   assign is_nop = sel_n | (opcode == OP_NOP);
   assign awake  = (st_q == ST_IDLE) | (st_q == ST_ACTIVE);

   pwr_cke_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .cke   (cke),
      .fall  (fall)
   );

   pwr_entry_dec #(
      .OP_W   (OP_W),
      .OP_REF (OP_REF),
      .OP_BST (OP_BST)
   ) u_dec (
      .bank_open (bank_open),
      .is_nop    (is_nop),
      .opcode    (opcode),
      .target    (entry_tgt),
      .illegal   (entry_bad)
   );

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_INIT:            if (init_done) st_d = ST_IDLE;
         ST_IDLE, ST_ACTIVE: st_d = fall ? entry_tgt
                                         : (bank_open ? ST_ACTIVE : ST_IDLE);
         ST_APD:             if (cke) st_d = ST_ACTIVE;
         ST_IPD, ST_SR:      if (cke) st_d = ST_IDLE;
         ST_DPD:             if (cke) st_d = ST_INIT;
         default:            st_d = ST_INIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_INIT;
      else        st_q <= st_d;
   end

   assign blocked = ~awake;
   assign err_set = (blocked & ~is_nop) | (awake & fall & entry_bad);

   pwr_err_flag #(.STICKY(ERR_STICKY)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (err_set),
      .flag  (proto_err)
   );

   assign pstate    = st_q;
   assign cmd_block = blocked;
endmodule

// File: rtl/pwr_state_chk.sv
module pwr_state_chk
   import pwr_pkg::*;
#(
   parameter int               OP_W       = 3,
   parameter logic [OP_W-1:0]  OP_BST     = 3'b110,
   parameter bit               ERR_STICKY = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cke,
   input logic               sel_n,
   input logic [OP_W-1:0]    opcode,
   input logic               bank_open,
   input logic               init_done,
   input logic [STATE_W-1:0] pstate,
   input logic               proto_err
);
   logic awake;
   assign awake = (pstate == ST_IDLE) || (pstate == ST_ACTIVE);

   a_r1_init_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pstate == ST_INIT && !init_done) |=> pstate == ST_INIT);

   a_r3_open_bank_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (awake && !cke && $past(cke) && bank_open) |=> pstate == ST_APD);

   a_r6_dpd_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (awake && !cke && $past(cke) && !bank_open && !sel_n && opcode == OP_BST)
      |=> pstate == ST_DPD);

   a_r8_sr_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (pstate == ST_SR && cke) |=> pstate == ST_IDLE);

   a_r9_dpd_leave: assert property (@(posedge clk) disable iff (!rst_n)
      (pstate == ST_DPD) |=> (pstate == ST_DPD || pstate == ST_INIT));

   a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ERR_STICKY && proto_err) |=> proto_err);
endmodule

bind pwr_state_ctl pwr_state_chk #(
   .OP_W       (OP_W),
   .OP_BST     (OP_BST),
   .ERR_STICKY (ERR_STICKY)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cke       (cke),
   .sel_n     (sel_n),
   .opcode    (opcode),
   .bank_open (bank_open),
   .init_done (init_done),
   .pstate    (pstate),
   .proto_err (proto_err)
);

// File: tb/test_pwr_state_ctl.sv
module test_pwr_state_ctl;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cke = 1'b0;
   logic       sel_n = 1'b1;
   logic [2:0] opcode = 3'b111;
   logic       bank_open = 1'b0;
   logic       init_done = 1'b0;
   logic [2:0] pstate;
   logic       cmd_block;
   logic       proto_err;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";

   // reference model
   int m_st = 0;
   bit m_ckeq = 0;
   bit m_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_state_ctl i_pwr_state_ctl (
      .clk(clk), .rst_n(rst_n), .cke(cke), .sel_n(sel_n), .opcode(opcode),
      .bank_open(bank_open), .init_done(init_done),
      .pstate(pstate), .cmd_block(cmd_block), .proto_err(proto_err)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_ckeq = 0; m_err = 0;
      end else begin
         bit nop, fall, blk;
         nop  = sel_n || (opcode == 3'b111);
         fall = !cke && m_ckeq;
         blk  = !(m_st == 1 || m_st == 2);
         if (blk && !nop) m_err = 1;
         case (m_st)
            0: if (init_done) m_st = 1;
            1, 2: begin
               if (fall) begin
                  if (bank_open)              m_st = 3;
                  else if (nop)               m_st = 4;
                  else if (opcode == 3'b001)  m_st = 5;
                  else if (opcode == 3'b110)  m_st = 6;
                  else begin m_st = 4; m_err = 1; end
               end else m_st = bank_open ? 2 : 1;
            end
            3: if (cke) m_st = 2;
            4, 5: if (cke) m_st = 1;
            6: if (cke) m_st = 0;
            default: m_st = 0;
         endcase
         m_ckeq = cke;
      end
   end

   task automatic compare();
      bit exp_blk;
      exp_blk = !(m_st == 1 || m_st == 2);
      checks++;
      if (pstate !== 3'(m_st) || cmd_block !== exp_blk || proto_err !== m_err) begin
         errors++;
         $display("FAIL %s state/block/err actual=%0d/%0b/%0b expected=%0d/%0b/%0b",
                  cur_req, pstate, cmd_block, proto_err, m_st, exp_blk, m_err);
      end
   endtask

   task automatic cyc(input logic k, input logic s, input logic [2:0] o,
                      input logic b, input logic d, input string req);
      cke = k; sel_n = s; opcode = o; bank_open = b; init_done = d; cur_req = req;
      @(negedge clk);
      compare();
   endtask

   task automatic do_reset();
      cur_req = "R1";
      rst_n = 1'b0;
      cke = 1'b0; sel_n = 1'b1; opcode = 3'b111; bank_open = 1'b0; init_done = 1'b0;
      @(negedge clk);
      compare();
      @(negedge clk);
      compare();
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R1: waits for init_done
      cyc(1, 1, 3'b111, 0, 0, "R1");
      cyc(1, 1, 3'b111, 0, 0, "R1");
      cyc(1, 1, 3'b111, 0, 1, "R1");
      // R2: tracking bank_open, ordinary commands accepted
      cyc(1, 1, 3'b111, 1, 0, "R2");
      cyc(1, 0, 3'b101, 1, 0, "R2");
      cyc(1, 1, 3'b111, 0, 0, "R2");
      cyc(1, 0, 3'b001, 0, 0, "R2");
      // R4: idle power-down via chip select high, then exit (R8)
      cyc(0, 1, 3'b000, 0, 0, "R4");
      cyc(0, 1, 3'b111, 0, 0, "R4");
      cyc(0, 1, 3'b111, 0, 0, "R8");
      cyc(1, 1, 3'b111, 0, 0, "R8");
      cyc(1, 1, 3'b111, 0, 0, "R2");
      // R4: idle power-down via opcode 111 with chip selected
      cyc(0, 0, 3'b111, 0, 0, "R4");
      cyc(1, 1, 3'b111, 0, 0, "R8");
      // R3: bank open wins over a refresh opcode, exit to active (R8)
      cyc(1, 1, 3'b111, 1, 0, "R3");
      cyc(0, 0, 3'b001, 1, 0, "R3");
      cyc(0, 1, 3'b111, 1, 0, "R3");
      cyc(1, 1, 3'b111, 1, 0, "R8");
      cyc(1, 1, 3'b111, 0, 0, "R2");
      // R5: self-refresh, hold, exit to idle
      cyc(0, 0, 3'b001, 0, 0, "R5");
      cyc(0, 1, 3'b111, 0, 0, "R5");
      cyc(0, 1, 3'b111, 0, 0, "R8");
      cyc(1, 1, 3'b111, 0, 0, "R8");
      // R6 / R9: deep power-down, init_done ignored, exit to init
      cyc(1, 1, 3'b111, 0, 0, "R6");
      cyc(0, 0, 3'b110, 0, 0, "R6");
      cyc(0, 1, 3'b111, 0, 1, "R9");
      cyc(0, 1, 3'b111, 0, 1, "R9");
      cyc(1, 1, 3'b111, 0, 0, "R9");
      cyc(1, 1, 3'b111, 0, 0, "R9");
      cyc(1, 1, 3'b111, 0, 1, "R9");
      cyc(1, 1, 3'b111, 0, 0, "R9");
      // R7: cke low from reset through init, no entry
      do_reset();
      cyc(0, 1, 3'b111, 0, 1, "R7");
      cyc(0, 0, 3'b001, 0, 0, "R7");
      cyc(0, 0, 3'b110, 1, 0, "R7");
      cyc(0, 0, 3'b110, 0, 0, "R7");
      cyc(1, 1, 3'b111, 0, 0, "R7");
      cyc(0, 0, 3'b110, 0, 0, "R7");
      cyc(1, 1, 3'b111, 0, 0, "R9");
      cyc(1, 1, 3'b111, 0, 1, "R9");
      // R10: illegal opcode at entry -> idle power-down + error, sticky
      cyc(1, 1, 3'b111, 0, 0, "R10");
      cyc(0, 0, 3'b101, 0, 0, "R10");
      cyc(0, 1, 3'b111, 0, 0, "R10");
      cyc(1, 1, 3'b111, 0, 0, "R10");
      cyc(1, 1, 3'b111, 0, 0, "R10");
      // R10: stray command inside idle power-down
      do_reset();
      cyc(1, 1, 3'b111, 0, 1, "R10");
      cyc(1, 1, 3'b111, 0, 0, "R10");
      cyc(0, 1, 3'b111, 0, 0, "R10");
      cyc(0, 0, 3'b011, 0, 0, "R10");
      cyc(0, 1, 3'b111, 0, 0, "R10");
      cyc(1, 1, 3'b111, 0, 0, "R10");
      // R10: command during initialisation wait
      do_reset();
      cyc(1, 0, 3'b100, 0, 0, "R10");
      cyc(1, 1, 3'b111, 0, 1, "R10");
      cyc(1, 1, 3'b111, 0, 0, "R10");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule